// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transceiver

This block is a byte-oriented asynchronous serial port that software drives through a small register file. A write into the transmit holding register, followed by clearing the transmit-empty flag, queues one character. The transmitter copies the holding register into its shift register as soon as the shifter is free and reports that the holding register is empty again. Software can therefore queue the next character while the current one is still on the line. On the receive side, a shift register assembles each incoming frame and then hands the character to a receive data register.

The character format is set in a mode register:

- 7 or 8 data bits;
- optional even or odd parity;
- one or two stop bits;
- a prescaler tap.

A separate direction register selects the bit order. The bit time comes from the prescaler and an 8-bit rate divider. The receiver samples at sixteen times the bit rate.

Status flags are set only by hardware. Software can only clear them, by writing zero. Four interrupt request lines are formed from the flags and their enables.

Top module: `sx_xcvr`

Register addresses (3-bit `addr_i`): 0 mode, 1 control, 2 rate divider, 3 transmit holding, 4 status, 5 received data (read-only), 6 direction. Any other address reads as zero.

## Requirements
- R1: After reset the status register reads 0x84, `txd_o` is 1, all four interrupt lines are 0 and the received-data register reads 0x00.
- R2: A transmitted frame consists of a 0 start bit, then the data bits, then the stop bit or bits at 1. The line idles at 1. One bit lasts prescale × 32 × (rate + 1) clock cycles. With mode 0x00 and direction 0x00, the 8 data bits are sent LSB first.
- R3: Mode bits 1:0 select the prescaler: code 0 divides by 1, code 1 by 8, code 2 by 32 and code 3 by 128.
- R4: Mode bit 4 enables a parity bit after the data bits. With mode bit 3 at 0 the parity is even (the data bits plus the parity bit hold an even number of ones). With mode bit 3 at 1 the parity is odd.
- R5: Direction-register bit 3 at 1 selects MSB-first order for 8-bit characters, on both transmit and receive. Mode bit 5 at 1 selects 7-bit characters, which are always sent LSB first.
- R6: When the shifter is free and status bit 7 (transmit-empty) is 0, the holding register moves to the shifter and bit 7 returns to 1 while the frame starts. A character queued during a frame follows it without a gap.
- R7: Status bit 2 (transmit-end) clears when a character enters the shifter. It sets when the last stop bit ends while bit 7 is 1.
- R8: A received frame is placed in the received-data register and sets status bit 6 (receive-full).
- R9: If a frame completes while bit 6 is still 1, status bit 5 (overrun) sets and the received-data register keeps its old value.
- R10: A stop bit sampled as 0 sets status bit 4 (framing). A parity mismatch sets status bit 3 (parity).
- R11: Writing the status register clears each flag in bits 7..2 whose written bit is 0. A written 1 leaves the flag unchanged. Bit 0 is plain storage.
- R12: The interrupt outputs are formed from the control register as follows:
  - transmit-empty request = control bit 7 AND transmit-empty;
  - receive-full request = control bit 6 AND receive-full;
  - error request = control bit 6 AND (overrun OR framing OR parity);
  - transmit-end request = control bit 2 AND transmit-end.

  Control bit 5 enables the transmitter and control bit 4 enables the receiver.
- R13: Mode bit 2 at 1 sends two stop bits, so that back-to-back frames keep the line high for two bit times between characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | Write strobe, qualified by `sel_i` |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_txe_o | output | 1 | Transmit-empty interrupt request |
| irq_rxf_o | output | 1 | Receive-full interrupt request |
| irq_err_o | output | 1 | Receive-error interrupt request |
| irq_tend_o | output | 1 | Transmit-end interrupt request |

## Verification
The following properties are checked on every cycle:

- the sample tick is a single-cycle pulse;
- every frame begins with a low start bit;
- a frame-complete pulse lasts one cycle;
- a character move sets transmit-empty and clears transmit-end;
- all-ones status writes never drop a flag;
- an overrun freezes the received-data register.

Only the bench scenarios can show the following:

- the bit order and parity on the line, and the bit time for each prescaler tap;
- the gap-free back-to-back frames with two stop bits;
- the error flags raised by corrupted frames arriving on the receive line.

// File: rtl/sx_pkg.sv
package sx_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_RATE = 3'd2;
    localparam logic [ADDR_W-1:0] A_TXH  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] A_RXH  = 3'd5;
    localparam logic [ADDR_W-1:0] A_DIR  = 3'd6;

    typedef struct packed {
        logic       sync_sel;
        logic       mp_mode;
        logic       seven;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
        logic [1:0] cks;
    } mode_t;

    typedef struct packed {
        logic       tie;
        logic       rie;
        logic       te;
        logic       re;
        logic       mpie;
        logic       teie;
        logic [1:0] cke;
    } ctrl_t;
endpackage

// File: rtl/sx_baud.sv
module sx_baud #(
    parameter int unsigned RATE_W    = 8,
    parameter int unsigned OVS       = 16,
    parameter int unsigned BIT_SCALE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cks_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    localparam int unsigned PRE_W    = 7;
    localparam int unsigned TICK_MUL = BIT_SCALE / OVS;
    localparam int unsigned DIV_W    = RATE_W + $clog2(TICK_MUL) + 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
        logic             tick;
    } st_t;

    st_t q, d;
    logic [PRE_W-1:0] pre_lim;
    logic [DIV_W-1:0] div_lim;

    always_comb begin
        case (cks_i)
            2'd0:    pre_lim = PRE_W'(0);
            2'd1:    pre_lim = PRE_W'(7);
            2'd2:    pre_lim = PRE_W'(31);
            default: pre_lim = PRE_W'(127);
        endcase
        div_lim = DIV_W'(TICK_MUL) * (DIV_W'(rate_i) + DIV_W'(1)) - DIV_W'(1);
        d      = q;
        d.tick = 1'b0;
        if (q.pre >= pre_lim) begin
            d.pre = '0;
            if (q.div >= div_lim) begin
                d.div  = '0;
                d.tick = 1'b1;
            end else begin
                d.div = q.div + DIV_W'(1);
            end
        end else begin
            d.pre = q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = q.tick;

    assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/sx_tx.sv
module sx_tx #(
    parameter int unsigned OVS     = 16,
    parameter int unsigned FRAME_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       en_i,
    input  logic       seven_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       two_stop_i,
    input  logic       msb_first_i,
    input  logic [7:0] hold_i,
    input  logic       hold_full_i,
    output logic       load_o,
    output logic       done_o,
    output logic       txd_o
);
    localparam int unsigned PH_W  = $clog2(OVS);
    localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   left;
        logic [PH_W-1:0]    ph;
    } st_t;

    st_t q, d;
    logic [7:0]         ordered;
    logic               par;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;

    always_comb begin
        for (int i = 0; i < 8; i++) ordered[i] = msb_first_i ? hold_i[7-i] : hold_i[i];
        par   = (seven_i ? ^hold_i[6:0] : ^hold_i) ^ par_odd_i;
        frame = '1;
        frame[0] = 1'b0;
        if (seven_i) begin
            frame[7:1] = hold_i[6:0];
            if (par_en_i) frame[8] = par;
        end else begin
            frame[8:1] = ordered;
            if (par_en_i) frame[9] = par;
        end
        nbits = CNT_W'(9) + CNT_W'(!seven_i) + CNT_W'(par_en_i) + CNT_W'(two_stop_i);

        d      = q;
        load_o = 1'b0;
        done_o = 1'b0;
        if (!q.busy) begin
            if (en_i && hold_full_i) begin
                load_o = 1'b1;
                d.busy = 1'b1;
                d.sh   = frame;
                d.left = nbits;
                d.ph   = '0;
            end
        end else if (tick_i) begin
            if (q.ph == PH_W'(OVS - 1)) begin
                d.ph   = '0;
                d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                d.left = q.left - CNT_W'(1);
                if (q.left == CNT_W'(1)) begin
                    done_o = 1'b1;
                    d.busy = 1'b0;
                    if (en_i && hold_full_i) begin
                        load_o = 1'b1;
                        d.busy = 1'b1;
                        d.sh   = frame;
                        d.left = nbits;
                    end
                end
            end else begin
                d.ph = q.ph + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, sh: '1, left: '0, ph: '0};
        else        q <= d;
    end

    assign txd_o = q.busy ? q.sh[0] : 1'b1;

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !txd_o);
    assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_o) |=> txd_o);
endmodule

// File: rtl/sx_rx.sv
module sx_rx #(
    parameter int unsigned OVS    = 16,
    parameter int unsigned BUF_W  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       en_i,
    input  logic       seven_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       msb_first_i,
    input  logic       rxd_i,
    output logic       done_o,
    output logic [7:0] data_o,
    output logic       perr_o,
    output logic       ferr_o
);
    localparam int unsigned PH_W  = $clog2(OVS);
    localparam int unsigned IDX_W = $clog2(BUF_W);

    typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rst_e;

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             prev;
        rst_e             st;
        logic [PH_W-1:0]  cnt;
        logic [IDX_W-1:0] idx;
        logic [BUF_W-1:0] bits;
        logic             done;
    } st_t;

    st_t q, d;
    logic [IDX_W-1:0] nafter;
    logic             par_rx, stop_rx, xsum;

    always_comb begin
        nafter = (seven_i ? IDX_W'(8) : IDX_W'(9)) + IDX_W'(par_en_i);
        d      = q;
        d.s1   = rxd_i;
        d.s2   = q.s1;
        d.prev = q.s2;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (en_i && q.prev && !q.s2) begin
                    d.st  = S_START;
                    d.cnt = '0;
                end
            end
            S_START: begin
                if (tick_i) begin
                    if (q.cnt == PH_W'(OVS / 2 - 1)) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = q.s2 ? S_IDLE : S_BITS;
                    end else begin
                        d.cnt = q.cnt + PH_W'(1);
                    end
                end
            end
            S_BITS: begin
                if (tick_i) begin
                    if (q.cnt == PH_W'(OVS - 1)) begin
                        d.cnt          = '0;
                        d.bits[q.idx]  = q.s2;
                        d.idx          = q.idx + IDX_W'(1);
                        if (q.idx == nafter - IDX_W'(1)) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + PH_W'(1);
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (seven_i) begin
            data_o  = {1'b0, q.bits[6:0]};
            xsum    = ^q.bits[6:0];
            par_rx  = q.bits[7];
            stop_rx = par_en_i ? q.bits[8] : q.bits[7];
        end else begin
            for (int i = 0; i < 8; i++) data_o[i] = msb_first_i ? q.bits[7-i] : q.bits[i];
            xsum    = ^q.bits[7:0];
            par_rx  = q.bits[8];
            stop_rx = par_en_i ? q.bits[9] : q.bits[8];
        end
        perr_o = par_en_i && (par_rx != (xsum ^ par_odd_i));
        ferr_o = !stop_rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1, st: S_IDLE, cnt: '0,
                           idx: '0, bits: '1, done: 1'b0};
        else        q <= d;
    end

    assign done_o = q.done;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/sx_xcvr.sv
module sx_xcvr
    import sx_pkg::*;
#(
    parameter int unsigned RATE_W = 8,
    parameter int unsigned OVS    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic       wr_i,
    input  logic [2:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic       rxd_i,
    output logic       txd_o,
    output logic       irq_txe_o,
    output logic       irq_rxf_o,
    output logic       irq_err_o,
    output logic       irq_tend_o
);
    typedef struct packed {
        mode_t             mode;
        ctrl_t             ctrl;
        logic [RATE_W-1:0] rate;
        logic [7:0]        dirr;
        logic [7:0]        tdr;
        logic [7:0]        rdr;
        logic              tdre;
        logic              rdrf;
        logic              orer;
        logic              fer;
        logic              per;
        logic              tend;
        logic              mpbt;
    } st_t;

    st_t q, d;
    logic       wr_en, tick, msb_first;
    logic       tx_load, tx_done;
    logic       rx_done, rx_perr, rx_ferr;
    logic [7:0] rx_data, stat_w;

    assign wr_en     = sel_i && wr_i;
    assign msb_first = q.dirr[3] && !q.mode.seven;
    assign stat_w    = {q.tdre, q.rdrf, q.orer, q.fer, q.per, q.tend, 1'b0, q.mpbt};

    sx_baud #(.RATE_W(RATE_W), .OVS(OVS), .BIT_SCALE(32)) u_baud (
        .clk(clk), .rst_n(rst_n), .cks_i(q.mode.cks), .rate_i(q.rate), .tick_o(tick));

    sx_tx #(.OVS(OVS), .FRAME_W(12)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(q.ctrl.te),
        .seven_i(q.mode.seven), .par_en_i(q.mode.par_en), .par_odd_i(q.mode.par_odd),
        .two_stop_i(q.mode.two_stop), .msb_first_i(msb_first),
        .hold_i(q.tdr), .hold_full_i(!q.tdre),
        .load_o(tx_load), .done_o(tx_done), .txd_o(txd_o));

    sx_rx #(.OVS(OVS), .BUF_W(10)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(q.ctrl.re),
        .seven_i(q.mode.seven), .par_en_i(q.mode.par_en), .par_odd_i(q.mode.par_odd),
        .msb_first_i(msb_first), .rxd_i(rxd_i),
        .done_o(rx_done), .data_o(rx_data), .perr_o(rx_perr), .ferr_o(rx_ferr));

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr_i)
                A_MODE: d.mode = mode_t'(wdata_i);
                A_CTRL: d.ctrl = ctrl_t'(wdata_i);
                A_RATE: d.rate = RATE_W'(wdata_i);
                A_TXH:  d.tdr  = wdata_i;
                A_DIR:  d.dirr = wdata_i;
                A_STAT: begin
                    d.tdre = q.tdre & wdata_i[7];
                    d.rdrf = q.rdrf & wdata_i[6];
                    d.orer = q.orer & wdata_i[5];
                    d.fer  = q.fer  & wdata_i[4];
                    d.per  = q.per  & wdata_i[3];
                    d.tend = q.tend & wdata_i[2];
                    d.mpbt = wdata_i[0];
                end
                default: ;
            endcase
        end
        if (tx_load) begin
            d.tdre = 1'b1;
            d.tend = 1'b0;
        end
        if (tx_done && q.tdre) d.tend = 1'b1;
        if (rx_done) begin
            if (q.rdrf) begin
                d.orer = 1'b1;
            end else begin
                d.rdr  = rx_data;
                d.rdrf = 1'b1;
                if (rx_perr) d.per = 1'b1;
                if (rx_ferr) d.fer = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{mode: '0, ctrl: '0, rate: '1, dirr: '0, tdr: '1, rdr: '0,
                           tdre: 1'b1, rdrf: 1'b0, orer: 1'b0, fer: 1'b0, per: 1'b0,
                           tend: 1'b1, mpbt: 1'b0};
        else        q <= d;
    end

    always_comb begin
        case (addr_i)
            A_MODE:  rdata_o = q.mode;
            A_CTRL:  rdata_o = q.ctrl;
            A_RATE:  rdata_o = 8'(q.rate);
            A_TXH:   rdata_o = q.tdr;
            A_STAT:  rdata_o = stat_w;
            A_RXH:   rdata_o = q.rdr;
            A_DIR:   rdata_o = q.dirr;
            default: rdata_o = 8'h00;
        endcase
    end

    assign irq_txe_o  = q.ctrl.tie  & q.tdre;
    assign irq_rxf_o  = q.ctrl.rie  & q.rdrf;
    assign irq_err_o  = q.ctrl.rie  & (q.orer | q.fer | q.per);
    assign irq_tend_o = q.ctrl.teie & q.tend;

    assert_clear_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_i == A_STAT && wdata_i[7:2] == 6'h3F && !tx_load && !tx_done && !rx_done)
        |=> (stat_w[7:2] == $past(stat_w[7:2])));
    assert_overrun_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && q.rdrf) |=> (q.orer && q.rdr == $past(q.rdr)));
    assert_load_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> (q.tdre && !q.tend));
endmodule

// File: tb/test_sx_xcvr.sv
module test_sx_xcvr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd, irq_txe, irq_rxf, irq_err, irq_tend;
    int         n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    sx_xcvr i_sx_xcvr (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd),
        .irq_txe_o(irq_txe), .irq_rxf_o(irq_rxf), .irq_err_o(irq_err), .irq_tend_o(irq_tend));

    // mode, direction, data, expected frame length in bits
    localparam logic [27:0] TXV [0:7] = '{
        {8'h00, 8'h00, 8'hA5, 4'd10},
        {8'h00, 8'h08, 8'h13, 4'd10},
        {8'h10, 8'h00, 8'h07, 4'd11},
        {8'h18, 8'h00, 8'h07, 4'd11},
        {8'h20, 8'h08, 8'hC1, 4'd9},
        {8'h01, 8'h00, 8'h5A, 4'd10},
        {8'h02, 8'h00, 8'h81, 4'd10},
        {8'h04, 8'h00, 8'hF0, 4'd11}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 v = rdata;
        sel = 1'b0;
    endtask

    function automatic int bit_period(input logic [7:0] m);
        case (m[1:0])
            2'd0: return 32;
            2'd1: return 256;
            2'd2: return 1024;
            default: return 4096;
        endcase
    endfunction

    function automatic logic [11:0] exp_frame(input logic [7:0] m, input logic [7:0] dr,
                                              input logic [7:0] dat);
        logic [11:0] f;
        int p;
        int nd;
        logic par;
        f = '1; f[0] = 1'b0; p = 1;
        nd = m[5] ? 7 : 8;
        par = m[3];
        for (int i = 0; i < nd; i++) begin
            logic b;
            b = (dr[3] && !m[5]) ? dat[7-i] : dat[i];
            f[p] = b;
            par = par ^ b;
            p++;
        end
        if (m[4]) f[p] = par;
        return f;
    endfunction

    task automatic capture(input int n, input int per, output logic [11:0] got);
        int w;
        w = 0;
        got = '1;
        while (txd === 1'b1 && w < 20000) begin @(negedge clk); w++; end
        repeat (per / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            if (i < n - 1) repeat (per) @(negedge clk);
        end
    endtask

    task automatic send(input logic [11:0] f, input int n, input int per);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rxd = f[i];
            repeat (per - 1) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [11:0] got, ga, gb, ef;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(3'd4, v); chk("R1 status", v, 8'h84);
        bus_rd(3'd5, v); chk("R1 rxdata", v, 8'h00);
        chk("R1 txd", txd, 1'b1);
        chk("R1 irqs", {irq_txe, irq_rxf, irq_err, irq_tend}, 4'b0000);

        // R11 all-ones write keeps flags, bit0 stores
        bus_wr(3'd4, 8'hFF); bus_rd(3'd4, v); chk("R11 ones keep", v, 8'h85);
        bus_wr(3'd4, 8'h84); bus_rd(3'd4, v); chk("R11 bit0 store", v, 8'h84);

        // R12 interrupt gating
        bus_wr(3'd1, 8'h80); chk("R12 txe on", irq_txe, 1'b1);
        bus_wr(3'd1, 8'h04); chk("R12 tend on", {irq_txe, irq_tend}, 2'b01);
        bus_wr(3'd1, 8'h30); chk("R12 all off", {irq_txe, irq_rxf, irq_err, irq_tend}, 4'b0000);
        bus_wr(3'd2, 8'h00);

        // Table-driven transmit frames: R2 R3 R4 R5 R13
        for (int k = 0; k < 8; k++) begin
            logic [7:0] m, dr, dt;
            int n, per;
            {m, dr, dt} = TXV[k][27:4];
            n = int'(TXV[k][3:0]);
            per = bit_period(m);
            bus_wr(3'd0, m);
            bus_wr(3'd6, dr);
            bus_wr(3'd3, dt);
            bus_wr(3'd4, 8'h7C);
            capture(n, per, got);
            chk($sformatf("R2/R3/R4/R5/R13 tx frame %0d", k), {20'd0, got}, {20'd0, exp_frame(m, dr, dt)});
            repeat (3 * per) @(negedge clk);
        end
        bus_wr(3'd6, 8'h00);

        // R6 R7 R13 back-to-back with two stop bits
        bus_wr(3'd0, 8'h04);
        bus_wr(3'd1, 8'h34);
        bus_wr(3'd3, 8'h3C);
        bus_wr(3'd4, 8'h7C);
        fork
            begin
                capture(11, 32, ga);
                capture(11, 32, gb);
            end
            begin
                repeat (4) @(negedge clk);
                bus_rd(3'd4, v); chk("R6 empty after move", v[7], 1'b1);
                chk("R7 tend low in frame", {v[2], irq_tend}, 2'b00);
                bus_wr(3'd3, 8'hC3);
                bus_wr(3'd4, 8'h7C);
            end
        join
        chk("R13 first of pair", {20'd0, ga}, {20'd0, exp_frame(8'h04, 8'h00, 8'h3C)});
        chk("R6 second of pair", {20'd0, gb}, {20'd0, exp_frame(8'h04, 8'h00, 8'hC3)});
        repeat (64) @(negedge clk);
        bus_rd(3'd4, v); chk("R7 tend set at end", v, 8'h84);
        chk("R7 tend irq", irq_tend, 1'b1);

        // Receive: R8 R9 R10 R5
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd1, 8'h70);
        send(exp_frame(8'h00, 8'h00, 8'hA5), 10, 32);
        repeat (8) @(negedge clk);
        bus_rd(3'd5, v); chk("R8 rxdata", v, 8'hA5);
        bus_rd(3'd4, v); chk("R8 rx full", v, 8'hC4);
        chk("R12 rxf irq", {irq_rxf, irq_err}, 2'b10);

        send(exp_frame(8'h00, 8'h00, 8'h3C), 10, 32);
        repeat (8) @(negedge clk);
        bus_rd(3'd5, v); chk("R9 rxdata kept", v, 8'hA5);
        bus_rd(3'd4, v); chk("R9 overrun", v, 8'hE4);
        chk("R12 err irq", irq_err, 1'b1);
        bus_wr(3'd4, 8'h84);
        bus_rd(3'd4, v); chk("R11 zero clears", v, 8'h84);
        chk("R11 err irq cleared", irq_err, 1'b0);

        ef = exp_frame(8'h00, 8'h00, 8'h55);
        ef[9] = 1'b0;
        send(ef, 10, 32);
        repeat (8) @(negedge clk);
        bus_rd(3'd4, v); chk("R10 framing", v, 8'hD4);
        bus_rd(3'd5, v); chk("R10 framing data", v, 8'h55);
        bus_wr(3'd4, 8'h84);

        bus_wr(3'd0, 8'h10);
        send(exp_frame(8'h10, 8'h00, 8'h07), 11, 32);
        repeat (8) @(negedge clk);
        bus_rd(3'd4, v); chk("R4 good parity rx", v, 8'hC4);
        bus_wr(3'd4, 8'h84);
        ef = exp_frame(8'h10, 8'h00, 8'h07);
        ef[9] = ~ef[9];
        send(ef, 11, 32);
        repeat (8) @(negedge clk);
        bus_rd(3'd4, v); chk("R10 parity error", v, 8'hCC);
        bus_wr(3'd4, 8'h84);

        bus_wr(3'd0, 8'h00);
        bus_wr(3'd6, 8'h08);
        send(exp_frame(8'h00, 8'h08, 8'hC4), 10, 32);
        repeat (8) @(negedge clk);
        bus_rd(3'd5, v); chk("R5 msb-first rx", v, 8'hC4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule